// File: doc/BRIEF.md
# Tag Grouping Span Generator

This block sits between hidden-surface removal and the shading stage of a tile renderer. It takes in the finished tag buffer of one tile, one tag per pixel in raster order. Each tag names the polygon whose shading and texturing parameters cover that pixel. The block then re-emits the coverage grouped by tag rather than in scan order. Every pixel that carries a given tag leaves the block before any pixel of the next tag. The shading stage can therefore keep one parameter set and its texture data resident while it works through the whole polygon.

The output is a stream of spans. Each span is a horizontal run of covered pixels inside one row, labelled with its tag, its row, its first column and its length. The spans pass through a small queue that acts as the shading stage's input buffer. A standard valid/ready handshake drains that queue. When the queue is full, the scan of the tile pauses.

A one-cycle completion pulse marks the point at which the final span of the tile has been taken. The block is ready for the next tile in that same cycle.

Top module: `tag_span_grouper`

## Requirements
- R1: While reset is held, and after it is released, `in_ready` is 1, `span_valid` is 0 and `tile_done` is 0.
- R2: While `in_ready` is high, each cycle with `in_valid` high stores one pixel tag. Pixel index k stands for row k/16, column k%16. After the 256th pixel, `in_ready` drops to 0 until the tile has been emitted.
- R3: Tag value 0 marks background and never appears on `span_tag`. A tile made only of background yields no spans and still raises `tile_done`.
- R4: Tags are served in the order in which each tag first occurs in raster order. All spans of one tag are emitted before any span of the next tag.
- R5: Within one tag, spans come out by ascending row, and by ascending start column within a row.
- R6: A span is a maximal run of equal tags within one row. It ends where the tag changes or where the row ends. Its length is 1 to 16 and start plus length never exceeds 16.
- R7: A span transfers on a clock edge where `span_valid` and `span_ready` are both high. While `span_valid` is high and `span_ready` is low, `span_valid` stays high and all span fields hold.
- R8: The output queue holds 32 spans. When the queue is full the scan stalls, and no span is lost or duplicated under any pattern of `span_ready`.
- R9: `tile_done` is a single-cycle pulse. It is raised only after the last span of the tile has transferred, and `in_ready` is high in the same cycle.
- R10: Pixels offered on `in_valid` while `in_ready` is low are ignored. They do not change the spans of the current tile or the contents of the next tile.
- R11: `span_tag` is 8 bits, `span_row` is 4 bits, `span_x` is 4 bits and `span_len` is 5 bits, with the length written as a plain binary count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A pixel tag is offered |
| in_tag | input | 8 | Tag of the offered pixel |
| in_ready | output | 1 | Block is loading a tile and takes pixels |
| span_valid | output | 1 | A span is presented |
| span_ready | input | 1 | Downstream takes the presented span |
| span_tag | output | 8 | Tag of the span |
| span_row | output | 4 | Row of the span |
| span_x | output | 4 | First column of the span |
| span_len | output | 5 | Number of pixels in the span |
| tile_done | output | 1 | Pulse after the last span of the tile has transferred |

## Verification
The bench builds the block with its default values: a 16x16 tile, 8-bit tags and a 32-span queue. One tile is a two-tag checkerboard that yields 256 one-pixel spans, eight times the queue depth. A ready pattern holds `span_ready` low for 150 cycles at a time, which fills the queue and keeps the scan stalled for long stretches. Other tiles reach the remaining cases:
- a tile whose first-seen tag is not the lowest tag;
- a tile with one covered pixel in the last corner;
- a tile that is all background;
- a tile loaded while garbage pixels are offered during the scan.

// File: rtl/tgsg_pkg.sv
package tgsg_pkg;

  typedef enum logic [1:0] {
    SC_LOAD  = 2'd0,
    SC_SEEK  = 2'd1,
    SC_EMIT  = 2'd2,
    SC_DRAIN = 2'd3
  } scan_state_e;

endpackage

// File: rtl/tgsg_tag_store.sv
// Per-pixel tag storage for one tile: one write port, one combinational read port.
module tgsg_tag_store #(
  parameter int TAG_W = 8,
  parameter int PIX   = 256
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [$clog2(PIX)-1:0]   wr_addr,
  input  logic [TAG_W-1:0]         wr_data,
  input  logic [$clog2(PIX)-1:0]   rd_addr,
  output logic [TAG_W-1:0]         rd_data
);

  logic [TAG_W-1:0] cell_q [PIX];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      cell_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = cell_q[rd_addr];

endmodule

// File: rtl/tgsg_span_fifo.sv
// Span queue between the scanner and the shading stage.
module tgsg_span_fifo #(
  parameter int DW    = 21,
  parameter int DEPTH = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  output logic          full,
  output logic          empty,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] slot_q [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pop;

  assign full      = (cnt_q == CW'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign out_valid = !empty;
  assign pop       = out_valid && out_ready;
  assign out_data  = slot_q[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) begin
      wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    end
    if (pop) begin
      rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    end
    if (push && !pop) begin
      cnt_d = cnt_q + 1'b1;
    end else if (pop && !push) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      slot_q[wr_q] <= push_data;
    end
  end

endmodule

// File: rtl/tgsg_scanner.sv
// Loads the tile, then runs one raster pass per distinct tag and cuts spans.
module tgsg_scanner
  import tgsg_pkg::*;
#(
  parameter int TILE_W = 16,
  parameter int TILE_H = 16,
  parameter int TAG_W  = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   in_valid,
  input  logic [TAG_W-1:0]                       in_tag,
  output logic                                   in_ready,
  output logic                                   wr_en,
  output logic [$clog2(TILE_W*TILE_H)-1:0]       wr_addr,
  output logic [TAG_W-1:0]                       wr_data,
  output logic [$clog2(TILE_W*TILE_H)-1:0]       rd_addr,
  input  logic [TAG_W-1:0]                       rd_tag,
  output logic                                   push,
  output logic [TAG_W+$clog2(TILE_H)+$clog2(TILE_W)+$clog2(TILE_W+1)-1:0] push_data,
  input  logic                                   fifo_full,
  input  logic                                   fifo_empty,
  output logic                                   tile_done
);

  localparam int X_W   = $clog2(TILE_W);
  localparam int Y_W   = $clog2(TILE_H);
  localparam int PIX   = TILE_W * TILE_H;
  localparam int PIX_W = $clog2(PIX);
  localparam int LEN_W = $clog2(TILE_W + 1);

  scan_state_e      state_q, state_d;
  logic [PIX_W-1:0] ptr_q, ptr_d;
  logic [PIX_W-1:0] base_q, base_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic             run_on_q, run_on_d;
  logic [X_W-1:0]   run_x_q, run_x_d;
  logic [LEN_W-1:0] run_len_q, run_len_d;
  logic [PIX-1:0]   used_q, used_d;
  logic             done_q, done_d;

  logic [X_W-1:0]   px_x;
  logic [Y_W-1:0]   px_y;
  logic             last_pix, row_end, hit, free_px;
  logic             push_req, step;
  logic [X_W-1:0]   sp_x;
  logic [LEN_W-1:0] sp_len;

  assign px_x     = ptr_q[X_W-1:0];
  assign px_y     = ptr_q[PIX_W-1:X_W];
  assign last_pix = (ptr_q == PIX_W'(PIX - 1));
  assign row_end  = (px_x == X_W'(TILE_W - 1));
  assign hit      = (rd_tag == tag_q);
  assign free_px  = (rd_tag != '0) && !used_q[ptr_q];

  assign in_ready  = (state_q == SC_LOAD);
  assign wr_en     = in_valid && in_ready;
  assign wr_addr   = ptr_q;
  assign wr_data   = in_tag;
  assign rd_addr   = ptr_q;
  assign tile_done = done_q;
  assign push_data = {tag_q, px_y, sp_x, sp_len};

  // span cut: a run closes on a tag change or on the last column
  always_comb begin
    push_req = 1'b0;
    sp_x     = run_x_q;
    sp_len   = run_len_q;
    if (state_q == SC_EMIT) begin
      if (hit && row_end) begin
        push_req = 1'b1;
        sp_x     = run_on_q ? run_x_q : px_x;
        sp_len   = run_on_q ? run_len_q + LEN_W'(1) : LEN_W'(1);
      end else if (!hit && run_on_q) begin
        push_req = 1'b1;
      end
    end
  end

  assign step = !(push_req && fifo_full);
  assign push = push_req && step;

  always_comb begin
    state_d   = state_q;
    ptr_d     = ptr_q;
    base_d    = base_q;
    tag_d     = tag_q;
    run_on_d  = run_on_q;
    run_x_d   = run_x_q;
    run_len_d = run_len_q;
    used_d    = used_q;
    done_d    = 1'b0;
    unique case (state_q)
      SC_LOAD: begin
        if (wr_en) begin
          if (last_pix) begin
            ptr_d   = '0;
            state_d = SC_SEEK;
          end else begin
            ptr_d = ptr_q + 1'b1;
          end
        end
      end
      SC_SEEK: begin
        if (free_px) begin
          tag_d    = rd_tag;
          base_d   = ptr_q;
          run_on_d = 1'b0;
          state_d  = SC_EMIT;
        end else if (last_pix) begin
          state_d = SC_DRAIN;
        end else begin
          ptr_d = ptr_q + 1'b1;
        end
      end
      SC_EMIT: begin
        if (step) begin
          if (hit) begin
            used_d[ptr_q] = 1'b1;
          end
          if (hit && !row_end) begin
            if (run_on_q) begin
              run_len_d = run_len_q + LEN_W'(1);
            end else begin
              run_x_d   = px_x;
              run_len_d = LEN_W'(1);
            end
            run_on_d = 1'b1;
          end else begin
            run_on_d = 1'b0;
          end
          if (last_pix) begin
            ptr_d   = base_q;
            state_d = SC_SEEK;
          end else begin
            ptr_d = ptr_q + 1'b1;
          end
        end
      end
      SC_DRAIN: begin
        if (fifo_empty) begin
          done_d  = 1'b1;
          used_d  = '0;
          ptr_d   = '0;
          state_d = SC_LOAD;
        end
      end
      default: state_d = SC_LOAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SC_LOAD;
      ptr_q     <= '0;
      base_q    <= '0;
      tag_q     <= '0;
      run_on_q  <= 1'b0;
      run_x_q   <= '0;
      run_len_q <= '0;
      used_q    <= '0;
      done_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      ptr_q     <= ptr_d;
      base_q    <= base_d;
      tag_q     <= tag_d;
      run_on_q  <= run_on_d;
      run_x_q   <= run_x_d;
      run_len_q <= run_len_d;
      used_q    <= used_d;
      done_q    <= done_d;
    end
  end

endmodule

// File: rtl/tag_span_grouper.sv
// Top: tag store, scanner and span queue, with a reset release synchronizer.
module tag_span_grouper #(
  parameter int TILE_W     = 16,
  parameter int TILE_H     = 16,
  parameter int TAG_W      = 8,
  parameter int FIFO_DEPTH = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [TAG_W-1:0]              in_tag,
  output logic                          in_ready,
  output logic                          span_valid,
  input  logic                          span_ready,
  output logic [TAG_W-1:0]              span_tag,
  output logic [$clog2(TILE_H)-1:0]     span_row,
  output logic [$clog2(TILE_W)-1:0]     span_x,
  output logic [$clog2(TILE_W+1)-1:0]   span_len,
  output logic                          tile_done
);

  localparam int X_W   = $clog2(TILE_W);
  localparam int Y_W   = $clog2(TILE_H);
  localparam int PIX   = TILE_W * TILE_H;
  localparam int PIX_W = $clog2(PIX);
  localparam int LEN_W = $clog2(TILE_W + 1);
  localparam int DW    = TAG_W + Y_W + X_W + LEN_W;

  logic             rst_meta_q, rst_sync_q;
  logic             wr_en;
  logic [PIX_W-1:0] wr_addr, rd_addr;
  logic [TAG_W-1:0] wr_data, rd_tag;
  logic             fifo_push, fifo_full, fifo_empty;
  logic [DW-1:0]    push_data, out_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  tgsg_tag_store #(.TAG_W(TAG_W), .PIX(PIX)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_tag)
  );

  tgsg_scanner #(.TILE_W(TILE_W), .TILE_H(TILE_H), .TAG_W(TAG_W)) u_scan (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .in_valid   (in_valid),
    .in_tag     (in_tag),
    .in_ready   (in_ready),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_tag     (rd_tag),
    .push       (fifo_push),
    .push_data  (push_data),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .tile_done  (tile_done)
  );

  tgsg_span_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .push      (fifo_push),
    .push_data (push_data),
    .full      (fifo_full),
    .empty     (fifo_empty),
    .out_valid (span_valid),
    .out_ready (span_ready),
    .out_data  (out_data)
  );

  assign {span_tag, span_row, span_x, span_len} = out_data;

endmodule

// File: rtl/tgsg_checker.sv
// Property checker, attached to the top module by bind.
module tgsg_checker #(
  parameter int TILE_W = 16,
  parameter int TILE_H = 16,
  parameter int TAG_W  = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        in_ready,
  input logic                        span_valid,
  input logic                        span_ready,
  input logic [TAG_W-1:0]            span_tag,
  input logic [$clog2(TILE_H)-1:0]   span_row,
  input logic [$clog2(TILE_W)-1:0]   span_x,
  input logic [$clog2(TILE_W+1)-1:0] span_len,
  input logic                        tile_done,
  input logic                        fifo_push,
  input logic                        fifo_full
);

  localparam int LEN_W = $clog2(TILE_W + 1);

  logic [LEN_W-1:0] span_end;
  assign span_end = LEN_W'(span_x) + span_len;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !fifo_push) else $error("queue overflow"); // R8

  AST_NO_BACKGROUND: assert property (@(posedge clk) disable iff (!rst_n)
    span_valid |-> span_tag != '0) else $error("background span"); // R3

  AST_SPAN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    span_valid |-> (span_len != '0) && (span_end <= LEN_W'(TILE_W))) else $error("span bounds"); // R6

  AST_SPAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    span_valid && !span_ready |=> span_valid && $stable({span_tag, span_row, span_x, span_len}))
    else $error("span not held"); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tile_done |=> !tile_done) else $error("done wider than one cycle"); // R9

  AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    tile_done |-> !span_valid && in_ready) else $error("done before drain"); // R9

  AST_LOAD_IDLE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !span_valid) else $error("span during load"); // R2

endmodule

bind tag_span_grouper tgsg_checker #(.TILE_W(TILE_W), .TILE_H(TILE_H), .TAG_W(TAG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .span_valid (span_valid),
  .span_ready (span_ready),
  .span_tag   (span_tag),
  .span_row   (span_row),
  .span_x     (span_x),
  .span_len   (span_len),
  .tile_done  (tile_done),
  .fifo_push  (fifo_push),
  .fifo_full  (fifo_full)
);

// File: tb/tag_span_grouper_test.sv
`timescale 1ns/1ps
module tag_span_grouper_test;

  localparam int DW = 21;

  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_tag;
  logic       in_ready;
  logic       span_valid;
  logic       span_ready;
  logic [7:0] span_tag;
  logic [3:0] span_row;
  logic [3:0] span_x;
  logic [4:0] span_len;
  logic       tile_done;

  int checks;
  int errors;
  int cyc;
  int done_cnt;
  int rdy_mode;
  logic [DW-1:0] exp_q[$];
  logic [7:0] tile [256];

  tag_span_grouper uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag), .in_ready(in_ready),
    .span_valid(span_valid), .span_ready(span_ready), .span_tag(span_tag), .span_row(span_row),
    .span_x(span_x), .span_len(span_len), .tile_done(tile_done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // watchdog
  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cyc);
        finish_run();
      end
    end
  end

  // ready driver, changes just after the edge
  initial begin
    span_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      case (rdy_mode)
        1:       span_ready = (cyc % 3) != 0;
        2:       span_ready = (cyc % 200) >= 150;
        default: span_ready = 1'b1;
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  logic          prev_stall;
  logic [DW-1:0] prev_data;
  logic          prev_done;
  initial begin
    prev_stall = 1'b0;
    prev_data  = '0;
    prev_done  = 1'b0;
    done_cnt   = 0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (prev_stall) begin
        chk(span_valid && ({span_tag, span_row, span_x, span_len} == prev_data),
            "R7 hold", int'({span_tag, span_row, span_x, span_len}), int'(prev_data));
      end
      if (span_valid && span_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4/R5/R6 unexpected span", int'({span_tag, span_row, span_x, span_len}), 0);
        end else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          chk({span_tag, span_row, span_x, span_len} == e, "R4/R5/R6/R11 span",
              int'({span_tag, span_row, span_x, span_len}), int'(e));
        end
      end
      if (tile_done) begin
        chk(exp_q.size() == 0, "R9 spans left at done", exp_q.size(), 0);
        chk(in_ready == 1'b1, "R9 ready at done", int'(in_ready), 1);
        chk(!prev_done, "R9 pulse width", int'(prev_done), 0);
        done_cnt++;
      end
      prev_done  = tile_done;
      prev_stall = span_valid && !span_ready;
      prev_data  = {span_tag, span_row, span_x, span_len};
    end
  end

  function automatic logic [7:0] pat(int id, int x, int y);
    int v;
    case (id)
      0: return 8'd0;
      1: return 8'd7;
      2: return ((x + y) % 2 == 1) ? 8'd2 : 8'd1;
      3: return (x >= 8) ? 8'd5 : ((y < 4) ? 8'd0 : 8'd3);
      4: begin
        v = (x * 5 + y * 3 + (x ^ y)) % 6;
        return 8'(v * 40);
      end
      default: return (x == 15 && y == 15) ? 8'd255 : 8'd0;
    endcase
  endfunction

  // expected spans straight from R3..R6
  task automatic build_expected(input int id);
    bit seen [256];
    logic [7:0] order[$];
    for (int p = 0; p < 256; p++) begin
      tile[p] = pat(id, p % 16, p / 16);
      seen[p] = 1'b0;
    end
    for (int p = 0; p < 256; p++) begin
      if (tile[p] != 0 && !seen[tile[p]]) begin
        seen[tile[p]] = 1'b1;
        order.push_back(tile[p]);
      end
    end
    foreach (order[i]) begin
      for (int y = 0; y < 16; y++) begin
        int x;
        x = 0;
        while (x < 16) begin
          if (tile[y * 16 + x] == order[i]) begin
            int s;
            s = x;
            while (x < 16 && tile[y * 16 + x] == order[i]) x++;
            exp_q.push_back({order[i], 4'(y), 4'(s), 5'(x - s)});
          end else begin
            x++;
          end
        end
      end
    end
  endtask

  task automatic run_tile(input int id, input int mode, input bit garbage);
    int old;
    rdy_mode = mode;
    build_expected(id);
    old = done_cnt;
    for (int p = 0; p < 256; p++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_tag   = tile[p];
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R2 busy after 256 pixels", int'(in_ready), 0);
    if (garbage) begin
      // R10: junk offered during the scan must leave no trace
      while (!tile_done) begin
        in_valid = 1'b1;
        in_tag   = 8'(cyc * 37 + 11);
        @(negedge clk);
      end
      in_valid = 1'b0;
    end
    while (done_cnt == old) @(negedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R8 all spans delivered", exp_q.size(), 0);
  endtask

  initial begin
    checks   = 0;
    errors   = 0;
    rdy_mode = 0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_tag   = 8'd0;
    repeat (4) @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
    chk(span_valid == 1'b0, "R1 span_valid in reset", int'(span_valid), 0);
    chk(tile_done == 1'b0, "R1 tile_done in reset", int'(tile_done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    chk(span_valid == 1'b0, "R1 span_valid after reset", int'(span_valid), 0);

    run_tile(0, 0, 1'b0);   // R3 all background
    run_tile(1, 1, 1'b0);   // R6 full rows of length 16
    run_tile(2, 2, 1'b0);   // R8 256 single-pixel spans under long stalls
    run_tile(3, 1, 1'b1);   // R4 first-seen order, R10 junk input
    run_tile(4, 0, 1'b0);   // R5 mixed runs
    run_tile(4, 2, 1'b0);   // R8 same tile with backpressure
    run_tile(5, 1, 1'b0);   // R6 corner pixel
    chk(done_cnt == 7, "R9 done count", done_cnt, 7);
    finish_run();
  end

endmodule